// File: doc/BRIEF.md
# Programmable chip-select address decoder

This block sits beside an external bus controller and picks the device that a bus cycle addresses. It holds ten address windows: eight chip-select windows, each driving one active-low select line, and two DRAM block windows, each driving one select toward a DRAM controller. Every window has a 16-bit base tag, a 16-bit don't-care mask over the upper address bits, a valid bit and a write-protect bit. It also has a control word that gives the port width, burst permission, a wait-state count and whether the block acknowledges the transfer by itself.

When the cycle-start strobe arrives in an idle state, the block decodes the upper address bits and the read/write attribute against every window. It registers the resulting selects and attributes and holds them until the cycle ends. The cycle ends with the internally generated acknowledge after the programmed wait states, or with an acknowledge from outside. The decoder has a fixed rule for every case. With no window hit it runs a default cycle. When several chip-select windows overlap it drives all of them in a conservative default cycle. When DRAM windows conflict it raises an error flag. After reset, chip select 0 answers every address so that boot code can be fetched from anywhere until software programs its mask word.

Top module: `csdec_top`

## Requirements
- R1: While reset is active and after reset, every `cs_n` line is high, `dram_sel` is 0, and `busy`, `ta` and `decode_err` are low.
- R2: A window hits when its valid bit (mask word bit 16) is set and `cyc_tag` equals its base tag in every bit whose mask bit (mask word bits 15:0) is 0. A single chip-select hit on window i drives `cs_n[i]` low. A single DRAM hit on window j (register index 8+j) drives `dram_sel[j]` high.
- R3: A window with its write-protect bit (mask word bit 17) set does not hit on a write cycle (`cyc_write`=1), but it still hits on reads.
- R4: From reset until the first write to chip select 0's mask word, chip select 0 hits on every address and attribute. Its control word resets to 32-bit port, no burst, 15 wait states and auto-acknowledge.
- R5: On a single hit, the outputs come from that window's control word. Bits 1:0 give `port_sz` (0 = 32-bit, 1 = 8-bit, 2 = 16-bit), bit 2 gives `burst_ok`, bits 6:3 give the wait-state count and bit 7 gives `auto_term`.
- R6: With no hit, the cycle runs with no select asserted, `port_sz`=0, `burst_ok`=0, `auto_term`=0 (external acknowledge) and `decode_err`=0.
- R7: When two or more chip-select windows hit and no DRAM window hits, every hitting `cs_n` line is driven low. The attributes are the defaults of R6.
- R8: When both DRAM windows hit, or a DRAM window and a chip-select window hit together, `decode_err` goes high for the cycle. No select is asserted and the attributes are the defaults of R6.
- R9: When `auto_term`=1 with wait count W, `busy` and the selects are held for W+1 clocks after the start edge. `ta` is high for exactly the last of those clocks.
- R10: When `auto_term`=0, `busy` and the selects are held until `ext_ack` is sampled high, and `ta` stays low.
- R11: The register write port (`reg_sel` 0-7 chip selects, 8-9 DRAM; `reg_fld` 0 base tag in data 15:0, 1 mask word, 2 control word in data 7:0) only updates while no cycle is in progress. A write during a busy cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Window index (0-7 chip select, 8-9 DRAM) |
| reg_fld | input | 2 | Register field: 0 base, 1 mask, 2 control |
| reg_wdata | input | 18 | Register write data |
| cyc_start | input | 1 | Bus cycle start strobe |
| cyc_tag | input | 16 | Upper address bits of the cycle |
| cyc_write | input | 1 | Cycle is a write |
| ext_ack | input | 1 | External transfer acknowledge |
| cs_n | output | 8 | Active-low chip-select lines |
| dram_sel | output | 2 | DRAM block selects |
| port_sz | output | 2 | Port width code of the current cycle |
| burst_ok | output | 1 | Burst permitted for the current cycle |
| auto_term | output | 1 | Cycle ends by internal acknowledge |
| decode_err | output | 1 | Undefined DRAM overlap in the current cycle |
| busy | output | 1 | Cycle in progress |
| ta | output | 1 | Internal transfer acknowledge pulse |

## Verification
The assertions assume that `ext_ack` is pulsed for one clock and only inside an external-termination cycle, and that `cyc_start` comes only when the block is idle. The stimulus issues one cycle at a time, waits for `busy` to fall plus one idle clock before the next, and raises `ext_ack` only for cycles predicted to need it. Register writes are made between cycles, apart from one deliberate write issued in the middle of a busy cycle to show that it is discarded.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

    localparam int NCS   = 8;
    localparam int NDR   = 2;
    localparam int NWIN  = NCS + NDR;
    localparam int TW    = 16;
    localparam int WSW   = 4;
    localparam int SELW  = $clog2(NWIN);

    typedef enum logic [1:0] {PS32 = 2'd0, PS8 = 2'd1, PS16 = 2'd2, PSX = 2'd3} psz_e;
    typedef enum logic [1:0] {F_BASE = 2'd0, F_MASK = 2'd1, F_CTRL = 2'd2, F_NONE = 2'd3} fld_e;
    typedef enum logic {ST_IDLE = 1'b0, ST_ACT = 1'b1} st_e;

    typedef struct packed {
        logic           aack;
        logic [WSW-1:0] ws;
        logic           burst;
        psz_e           psz;
    } ctrl_t;

    typedef struct packed {
        logic          wp;
        logic          valid;
        logic [TW-1:0] dc;
    } mask_t;

    localparam int DW = $bits(mask_t);
    localparam int CW = $bits(ctrl_t);

    localparam ctrl_t CTRL_DFLT = '{aack: 1'b0, ws: '0, burst: 1'b0, psz: PS32};
    localparam ctrl_t CTRL_BOOT = '{aack: 1'b1, ws: '1, burst: 1'b0, psz: PS32};

    function automatic logic win_hit(logic [TW-1:0] tag, logic [TW-1:0] base,
                                     mask_t m, logic wr);
        return m.valid && (((tag ^ base) & ~m.dc) == '0) && !(m.wp && wr);
    endfunction

endpackage

// File: rtl/csdec_regs.sv
module csdec_regs
    import csdec_pkg::*;
#(
    parameter int N = NWIN
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [SELW-1:0]       sel,
    input  logic [1:0]            fld,
    input  logic [DW-1:0]         wdata,
    output logic [N-1:0][TW-1:0]  base_q,
    output mask_t [N-1:0]         mask_q,
    output ctrl_t [N-1:0]         ctrl_q,
    output logic                  boot_glob
);

    for (genvar i = 0; i < N; i++) begin : g_win
        logic hit_sel;
        assign hit_sel = we && (sel == SELW'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[i] <= '0;
                mask_q[i] <= '0;
                ctrl_q[i] <= (i == 0) ? CTRL_BOOT : CTRL_DFLT;
            end else if (hit_sel) begin
                case (fld_e'(fld))
                    F_BASE:  base_q[i] <= wdata[TW-1:0];
                    F_MASK:  mask_q[i] <= mask_t'(wdata);
                    F_CTRL:  ctrl_q[i] <= ctrl_t'(wdata[CW-1:0]);
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            boot_glob <= 1'b1;
        else if (we && sel == '0 && fld_e'(fld) == F_MASK)
            boot_glob <= 1'b0;
    end

endmodule

// File: rtl/csdec_match.sv
module csdec_match
    import csdec_pkg::*;
#(
    parameter int N = NWIN
) (
    input  logic [TW-1:0]         tag,
    input  logic                  wr,
    input  logic [N-1:0][TW-1:0]  base_q,
    input  mask_t [N-1:0]         mask_q,
    input  logic                  boot_glob,
    output logic [N-1:0]          hit
);

    for (genvar i = 0; i < N; i++) begin : g_cmp
        if (i == 0) begin : g_boot
            assign hit[i] = boot_glob || win_hit(tag, base_q[i], mask_q[i], wr);
        end else begin : g_norm
            assign hit[i] = win_hit(tag, base_q[i], mask_q[i], wr);
        end
    end

endmodule

// File: rtl/csdec_resolve.sv
module csdec_resolve
    import csdec_pkg::*;
(
    input  logic [NWIN-1:0]    hit,
    input  ctrl_t [NWIN-1:0]   ctrl_q,
    output logic [NCS-1:0]     cs_sel,
    output logic [NDR-1:0]     dr_sel,
    output ctrl_t              attr,
    output logic               err
);

    logic [NCS-1:0] cs_hit;
    logic [NDR-1:0] dr_hit;
    int             ncs, ndr;

    assign cs_hit = hit[NCS-1:0];
    assign dr_hit = hit[NWIN-1:NCS];

    always_comb begin
        ncs    = $countones(cs_hit);
        ndr    = $countones(dr_hit);
        attr   = CTRL_DFLT;
        cs_sel = '0;
        dr_sel = '0;
        err    = 1'b0;
        if (ndr > 1 || (ndr == 1 && ncs != 0)) begin
            err = 1'b1;
        end else if (ndr == 1) begin
            dr_sel = dr_hit;
            for (int j = 0; j < NDR; j++)
                if (dr_hit[j]) attr = ctrl_q[NCS+j];
        end else if (ncs == 1) begin
            cs_sel = cs_hit;
            for (int i = 0; i < NCS; i++)
                if (cs_hit[i]) attr = ctrl_q[i];
        end else if (ncs > 1) begin
            cs_sel = cs_hit;
        end
    end

endmodule

// File: rtl/csdec_top.sv
module csdec_top
    import csdec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [SELW-1:0] reg_sel,
    input  logic [1:0]      reg_fld,
    input  logic [DW-1:0]   reg_wdata,
    input  logic            cyc_start,
    input  logic [TW-1:0]   cyc_tag,
    input  logic            cyc_write,
    input  logic            ext_ack,
    output logic [NCS-1:0]  cs_n,
    output logic [NDR-1:0]  dram_sel,
    output logic [1:0]      port_sz,
    output logic            burst_ok,
    output logic            auto_term,
    output logic            decode_err,
    output logic            busy,
    output logic            ta
);

    st_e                 st;
    ctrl_t               attr_q;
    logic [WSW-1:0]      wcnt;
    logic                err_q;
    logic [NCS-1:0]      csn_q;
    logic [NDR-1:0]      dr_q;

    logic [NWIN-1:0][TW-1:0] base_q;
    mask_t [NWIN-1:0]        mask_q;
    ctrl_t [NWIN-1:0]        ctrl_q;
    logic                    boot_glob;
    logic [NWIN-1:0]         hit;
    logic [NCS-1:0]          cs_sel;
    logic [NDR-1:0]          dr_sel;
    ctrl_t                   attr_c;
    logic                    err_c;

    logic idle, start, fin, ta_c;

    assign idle  = (st == ST_IDLE);
    assign start = idle && cyc_start;
    assign ta_c  = (st == ST_ACT) && attr_q.aack && (wcnt == '0);
    assign fin   = (st == ST_ACT) && (attr_q.aack ? (wcnt == '0) : ext_ack);

    csdec_regs #(.N(NWIN)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we && idle),
        .sel       (reg_sel),
        .fld       (reg_fld),
        .wdata     (reg_wdata),
        .base_q    (base_q),
        .mask_q    (mask_q),
        .ctrl_q    (ctrl_q),
        .boot_glob (boot_glob)
    );

    csdec_match #(.N(NWIN)) u_match (
        .tag       (cyc_tag),
        .wr        (cyc_write),
        .base_q    (base_q),
        .mask_q    (mask_q),
        .boot_glob (boot_glob),
        .hit       (hit)
    );

    csdec_resolve u_res (
        .hit    (hit),
        .ctrl_q (ctrl_q),
        .cs_sel (cs_sel),
        .dr_sel (dr_sel),
        .attr   (attr_c),
        .err    (err_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            csn_q  <= '1;
            dr_q   <= '0;
            attr_q <= CTRL_DFLT;
            err_q  <= 1'b0;
            wcnt   <= '0;
        end else if (start) begin
            st     <= ST_ACT;
            csn_q  <= ~cs_sel;
            dr_q   <= dr_sel;
            attr_q <= attr_c;
            err_q  <= err_c;
            wcnt   <= attr_c.ws;
        end else if (fin) begin
            st     <= ST_IDLE;
            csn_q  <= '1;
            dr_q   <= '0;
            attr_q <= CTRL_DFLT;
            err_q  <= 1'b0;
            wcnt   <= '0;
        end else if (st == ST_ACT && attr_q.aack) begin
            wcnt   <= wcnt - 1'b1;
        end
    end

    assign cs_n       = csn_q;
    assign dram_sel   = dr_q;
    assign port_sz    = attr_q.psz;
    assign burst_ok   = attr_q.burst;
    assign auto_term  = attr_q.aack;
    assign decode_err = err_q;
    assign busy       = (st == ST_ACT);
    assign ta         = ta_c;

endmodule

// File: rtl/csdec_chk.sv
module csdec_chk
    import csdec_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           ext_ack,
    input logic [NCS-1:0] cs_n,
    input logic [NDR-1:0] dram_sel,
    input logic [1:0]     port_sz,
    input logic           burst_ok,
    input logic           auto_term,
    input logic           decode_err,
    input logic           busy,
    input logic           ta
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (&cs_n) && (dram_sel == '0) && !ta);

    // R2
    dram_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dram_sel));

    // R7
    multi_dflt_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(~cs_n) > 1) |-> !burst_ok && !auto_term && (port_sz == 2'd0));

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        decode_err |-> (&cs_n) && (dram_sel == '0) && !auto_term);

    // R9
    ta_end_chk: assert property (@(posedge clk) disable iff (rst)
        ta |=> !busy && (&cs_n));

    // R10
    ext_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !auto_term && !ext_ack |=> busy && $stable(cs_n));

    // R10
    ext_no_ta_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !auto_term |-> !ta);

endmodule

bind csdec_top csdec_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ext_ack    (ext_ack),
    .cs_n       (cs_n),
    .dram_sel   (dram_sel),
    .port_sz    (port_sz),
    .burst_ok   (burst_ok),
    .auto_term  (auto_term),
    .decode_err (decode_err),
    .busy       (busy),
    .ta         (ta)
);

// File: tb/sim_csdec_top.sv
`timescale 1ns/1ps
module sim_csdec_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [1:0]  reg_fld = '0;
    logic [17:0] reg_wdata = '0;
    logic        cyc_start = 1'b0;
    logic [15:0] cyc_tag = '0;
    logic        cyc_write = 1'b0;
    logic        ext_ack = 1'b0;
    logic [7:0]  cs_n;
    logic [1:0]  dram_sel;
    logic [1:0]  port_sz;
    logic        burst_ok, auto_term, decode_err, busy, ta;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    csdec_top u0 (.*);

    typedef struct packed {
        logic [7:0]  csn;
        logic [1:0]  dr;
        logic [1:0]  psz;
        logic        burst;
        logic        aack;
        logic        err;
        logic [7:0]  len;
        logic [23:0] tag;
    } item_t;

    item_t exp_q[$];

    logic [15:0] sbase [10];
    logic [17:0] smask [10];
    logic [7:0]  sctrl [10];
    logic        sglob;

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic item_t predict(logic [15:0] t, logic wr, int ext_wait);
        item_t e;
        logic [7:0] csh;
        logic [1:0] drh;
        logic [7:0] c;
        int ncs, ndr;
        csh = '0; drh = '0;
        for (int w = 0; w < 10; w++) begin
            logic h;
            h = smask[w][16] && (((t ^ sbase[w]) & ~smask[w][15:0]) == 16'h0)
                && !(smask[w][17] && wr);
            if (w == 0 && sglob) h = 1'b1;
            if (w < 8) csh[w] = h; else drh[w-8] = h;
        end
        ncs = $countones(csh);
        ndr = $countones(drh);
        c = 8'h00;
        e = '0;
        e.csn = 8'hFF;
        if (ndr > 1 || (ndr == 1 && ncs > 0)) begin
            e.err = 1'b1;
        end else if (ndr == 1) begin
            e.dr = drh;
            c = drh[0] ? sctrl[8] : sctrl[9];
        end else if (ncs == 1) begin
            e.csn = ~csh;
            for (int i = 0; i < 8; i++) if (csh[i]) c = sctrl[i];
        end else if (ncs > 1) begin
            e.csn = ~csh;
        end
        e.psz   = c[1:0];
        e.burst = c[2];
        e.aack  = c[7];
        e.len   = c[7] ? (8'(c[6:3]) + 8'd1) : 8'(ext_wait + 1);
        return e;
    endfunction

    task automatic wr_reg(int sel, int fld, logic [17:0] d, bit apply);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 4'(sel); reg_fld = 2'(fld); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (apply) begin
            if (fld == 0) sbase[sel] = d[15:0];
            if (fld == 1) begin smask[sel] = d; if (sel == 0) sglob = 1'b0; end
            if (fld == 2) sctrl[sel] = d[7:0];
        end
    endtask

    task automatic run_cyc(logic [15:0] t, logic wr, int ext_wait, logic [23:0] tag);
        item_t e;
        e = predict(t, wr, ext_wait);
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        cyc_start = 1'b1; cyc_tag = t; cyc_write = wr;
        @(negedge clk);
        cyc_start = 1'b0;
        if (!e.aack) begin
            repeat (ext_wait) @(negedge clk);
            ext_ack = 1'b1;
            @(negedge clk);
            ext_ack = 1'b0;
        end else begin
            while (busy) @(negedge clk);
        end
        @(negedge clk);
    endtask

    // monitor: pops expected cycle descriptions as the design starts cycles
    initial begin
        item_t cur;
        bit    inb = 0;
        int    len = 0, tac = 0;
        cur = '0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (busy && !inb) begin
                    inb = 1; len = 1; tac = ta ? 1 : 0;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "scoreboard", 32'h0, 32'h1);
                    end else begin
                        cur = exp_q.pop_front();
                        check({cs_n, dram_sel, port_sz, burst_ok, auto_term, decode_err}
                              == {cur.csn, cur.dr, cur.psz, cur.burst, cur.aack, cur.err},
                              $sformatf("%s attrs", cur.tag),
                              32'({cs_n, dram_sel, port_sz, burst_ok, auto_term, decode_err}),
                              32'({cur.csn, cur.dr, cur.psz, cur.burst, cur.aack, cur.err}));
                    end
                end else if (busy && inb) begin
                    len++;
                    if (ta) tac++;
                end else if (!busy && inb) begin
                    inb = 0;
                    check(len == int'(cur.len), $sformatf("%s length R9/R10", cur.tag),
                          32'(len), 32'(cur.len));
                    check(tac == (cur.aack ? 1 : 0), $sformatf("%s ta count R9/R10", cur.tag),
                          32'(tac), cur.aack ? 32'd1 : 32'd0);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 10; w++) begin
            sbase[w] = '0; smask[w] = '0; sctrl[w] = '0;
        end
        sctrl[0] = 8'hF8;
        sglob = 1'b1;

        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check(cs_n == 8'hFF && !busy && !ta && !decode_err && dram_sel == 2'b00,
              "R1 in reset", 32'({cs_n, busy, ta, decode_err}), 32'({8'hFF, 3'b000}));
        rst = 1'b0;
        @(negedge clk);
        check(cs_n == 8'hFF && !busy && !ta && !decode_err && dram_sel == 2'b00,
              "R1 after reset", 32'({cs_n, busy, ta, decode_err}), 32'({8'hFF, 3'b000}));

        // R4: global boot select, any address and attribute
        run_cyc(16'h1234, 1'b0, 0, "R4");
        run_cyc(16'hABCD, 1'b1, 0, "R4");

        // R7: CS1 overlaps the still-global CS0
        wr_reg(1, 0, 18'h00010, 1);
        wr_reg(1, 1, 18'h1000F, 1);
        wr_reg(1, 2, 18'h00095, 1);
        run_cyc(16'h0015, 1'b0, 2, "R7");

        // R4: programming CS0 mask ends global mode; R5 single hit attributes
        wr_reg(0, 0, 18'h0FF00, 1);
        wr_reg(0, 1, 18'h100FF, 1);
        run_cyc(16'h0015, 1'b0, 0, "R5");
        run_cyc(16'hFF12, 1'b1, 0, "R2");

        // R6: no hit
        run_cyc(16'h5000, 1'b0, 1, "R6");

        // R3: write-protected CS2, external termination
        wr_reg(2, 0, 18'h02000, 1);
        wr_reg(2, 1, 18'h30000, 1);
        wr_reg(2, 2, 18'h00002, 1);
        run_cyc(16'h2000, 1'b0, 0, "R10");
        run_cyc(16'h2000, 1'b1, 2, "R3");

        // R2: single DRAM hit
        wr_reg(8, 0, 18'h04000, 1);
        wr_reg(8, 1, 18'h10FFF, 1);
        wr_reg(8, 2, 18'h0008C, 1);
        run_cyc(16'h4100, 1'b0, 0, "R2");

        // R8: both DRAM windows
        wr_reg(9, 0, 18'h04000, 1);
        wr_reg(9, 1, 18'h100FF, 1);
        run_cyc(16'h4000, 1'b0, 1, "R8");

        // R8: DRAM and chip select together
        wr_reg(3, 0, 18'h04100, 1);
        wr_reg(3, 1, 18'h10000, 1);
        run_cyc(16'h4100, 1'b1, 1, "R8");

        // R2: cleared valid bit removes CS1
        wr_reg(1, 1, 18'h0000F, 1);
        run_cyc(16'h0015, 1'b0, 1, "R2");

        // R11: write to CS2 base during a busy cycle is discarded
        fork
            run_cyc(16'h2000, 1'b0, 4, "R11");
            begin
                repeat (3) @(negedge clk);
                wr_reg(2, 0, 18'h03000, 0);
            end
        join
        run_cyc(16'h2000, 1'b0, 1, "R11");
        run_cyc(16'h3000, 1'b0, 1, "R11");

        // R7: two programmed chip selects overlap
        wr_reg(4, 0, 18'h02000, 1);
        wr_reg(4, 1, 18'h100FF, 1);
        wr_reg(4, 2, 18'h00095, 1);
        run_cyc(16'h2000, 1'b0, 1, "R7");

        // R9: CS4 alone with two wait states and auto-acknowledge
        run_cyc(16'h20A0, 1'b0, 0, "R9");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule